// File: doc/BRIEF.md
# Cascadable Dual Edge Counter

This block counts active edges on two external pulse inputs. Each input passes through a synchronizer and an edge detector. In split mode, two 8-bit counters run side by side, and each counts only when its own enable bit is set. Setting the cascade bit joins the pair into one 16-bit counter:

- The low byte counts edges on the channel-0 pin, which is the pin that the input-capture channel 0 of the surrounding timer also uses.
- The high byte advances each time the low byte wraps.
- The individual enables and the channel-1 pin then have no effect.

The block has no timer-enable input, so the count never depends on whether the main timer runs.

A small register bus reaches everything. It has a write strobe, an address, and write and read data. The read data is combinational from the address. Both count bytes keep their own addresses in either mode. A wrap of the joined 16-bit count sets a sticky overflow flag, which software clears by writing 1 to it. An interrupt line is raised while both the flag and its enable bit are set.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset every register reads 0x00 and irq is 0.
- R2: The mode register (address 0) keeps only bit 6 (cascade) and bit 1 (interrupt enable). All other bits read as 0 whatever was written.
- R3: With cascade off, the low counter (address 3) counts channel-0 edges only while enable bit 0 of address 1 is set. The high counter (address 4) counts channel-1 edges only while enable bit 1 is set. A disabled counter holds its value.
- R4: With cascade off, each 8-bit counter wraps from 0xFF to 0x00 on its own, and the overflow flag (bit 0 of address 2) stays 0.
- R5: With cascade on, addresses 4 and 3 read as the high and low bytes of one 16-bit count. The low byte counts channel-0 edges, and the high byte increments when the low byte wraps. Both enable bits and the channel-1 pin have no effect.
- R6: In cascade mode a wrap of the count from 0xFFFF to 0x0000 sets the overflow flag.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If a clear and a new overflow fall in the same cycle, the flag ends up set.
- R8: irq is 1 exactly when the interrupt enable and the overflow flag are both 1.
- R9: A bus write to a count byte loads that byte. A load in the same cycle as an increment wins, and the increment is lost.
- R10: A count advances by exactly one per rising edge of its pin. A level held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_ch0 | input | 1 | Pulse input for the low counter, shared with capture channel 0 |
| pin_ch1 | input | 1 | Pulse input for the high counter in split mode |
| irq | output | 1 | Overflow interrupt request |

## Verification
The pulse trains are applied in three ways:

- **Short pulses on one pin at a time, under each enable combination.** These show whether each counter responds only to its own pin and enable.
- **A level held high for many cycles.** This separates edge counting from level counting.
- **Preloaded values one step below a wrap, in both modes.** These show whether a carry crosses into the high byte and raises the flag only when the counters are joined.

Two further cases align a bus write with the exact cycle in which a synchronized edge lands. They test that a count load beats an increment, and that a new overflow beats a flag clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int ADDR_MODE   = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_FLAG   = 2;
  localparam int ADDR_CNT_LO = 3;
  localparam int ADDR_CNT_HI = 4;

  localparam int BIT_CASCADE = 6;
  localparam int BIT_IRQ_EN  = 1;
  localparam int BIT_EN_LO   = 0;
  localparam int BIT_EN_HI   = 1;
  localparam int BIT_OVF     = 0;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2,
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_pulse
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    last_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  generate
    if (RISING) begin : g_rise
      assign edge_pulse = level & ~last_q;
    end else begin : g_fall
      assign edge_pulse = ~level & last_q;
    end
  endgenerate

  // A level held steady never yields two pulses in a row
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/pa_byte_cnt.sv
module pa_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | inc;
    if (ld)       cnt_d = ld_val;
    else          cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = inc & ~ld & (&cnt_q);

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt_q));
  p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair
  import pa_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit RISING      = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pin_ch0,
  input  logic          pin_ch1,
  output logic          irq
);
  localparam int NCH = 2;

  logic casc_q, casc_d, ie_q, ie_d, en_lo_q, en_lo_d, en_hi_q, en_hi_d;
  logic ovf_q, ovf_d;
  logic wr_mode, wr_en, wr_flag, wr_lo, wr_hi;
  logic [NCH-1:0] pins, edges;
  logic inc_lo, inc_hi, wrap_lo, wrap_hi, ovf_set;
  logic [DW-1:0] cnt_lo, cnt_hi;

  assign pins = {pin_ch1, pin_ch0};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_in
      pa_sync_edge #(.STAGES(SYNC_STAGES), .RISING(RISING)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pins[i]), .edge_pulse(edges[i]));
    end
  endgenerate

  always_comb begin
    wr_mode = bus_wr && (bus_addr == AW'(ADDR_MODE));
    wr_en   = bus_wr && (bus_addr == AW'(ADDR_ENABLE));
    wr_flag = bus_wr && (bus_addr == AW'(ADDR_FLAG));
    wr_lo   = bus_wr && (bus_addr == AW'(ADDR_CNT_LO));
    wr_hi   = bus_wr && (bus_addr == AW'(ADDR_CNT_HI));
  end

  // Counter steering: joined mode ignores the individual enables
  always_comb begin
    if (casc_q) begin
      inc_lo = edges[0];
      inc_hi = wrap_lo;
    end else begin
      inc_lo = edges[0] & en_lo_q;
      inc_hi = edges[1] & en_hi_q;
    end
  end

  pa_byte_cnt #(.W(DW)) u_lo (
    .clk(clk), .rst_n(rst_n), .inc(inc_lo), .ld(wr_lo),
    .ld_val(bus_wdata), .cnt(cnt_lo), .wrap(wrap_lo));

  pa_byte_cnt #(.W(DW)) u_hi (
    .clk(clk), .rst_n(rst_n), .inc(inc_hi), .ld(wr_hi),
    .ld_val(bus_wdata), .cnt(cnt_hi), .wrap(wrap_hi));

  always_comb begin
    casc_d  = wr_mode ? bus_wdata[BIT_CASCADE] : casc_q;
    ie_d    = wr_mode ? bus_wdata[BIT_IRQ_EN]  : ie_q;
    en_lo_d = wr_en   ? bus_wdata[BIT_EN_LO]   : en_lo_q;
    en_hi_d = wr_en   ? bus_wdata[BIT_EN_HI]   : en_hi_q;
    ovf_set = casc_q & wrap_hi;
    if (ovf_set)                            ovf_d = 1'b1;
    else if (wr_flag && bus_wdata[BIT_OVF]) ovf_d = 1'b0;
    else                                    ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q  <= 1'b0;
      ie_q    <= 1'b0;
      en_lo_q <= 1'b0;
      en_hi_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_mode) begin
        casc_q <= casc_d;
        ie_q   <= ie_d;
      end
      if (wr_en) begin
        en_lo_q <= en_lo_d;
        en_hi_q <= en_hi_d;
      end
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADDR_MODE): begin
        bus_rdata[BIT_CASCADE] = casc_q;
        bus_rdata[BIT_IRQ_EN]  = ie_q;
      end
      AW'(ADDR_ENABLE): begin
        bus_rdata[BIT_EN_LO] = en_lo_q;
        bus_rdata[BIT_EN_HI] = en_hi_q;
      end
      AW'(ADDR_FLAG):   bus_rdata[BIT_OVF] = ovf_q;
      AW'(ADDR_CNT_LO): bus_rdata = cnt_lo;
      AW'(ADDR_CNT_HI): bus_rdata = cnt_hi;
      default:          bus_rdata = '0;
    endcase
  end

  assign irq = ie_q & ovf_q;

  p_ovf_joined_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(casc_q));
  p_ovf_from_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_hi == '0 && cnt_lo == '0));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && bus_wdata[BIT_OVF] && !(casc_q && wrap_hi)) |=> !ovf_q);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ovf_q);
endmodule

// File: tb/sim_pulse_acc_pair.sv
module sim_pulse_acc_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pin_ch0 = 1'b0, pin_ch1 = 1'b0;
  logic       irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_acc_pair u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_ch0(pin_ch0),
    .pin_ch1(pin_ch1), .irq(irq));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic pulses(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch == 0) pin_ch0 = 1'b1; else pin_ch1 = 1'b1;
      repeat (3) @(negedge clk);
      if (ch == 0) pin_ch0 = 1'b0; else pin_ch1 = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // Rising edge on channel 0 whose increment lands on the same edge as a write
  task automatic edge_with_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    pin_ch0 = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    pin_ch0 = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd_check("R1 reg", 3'(a), 8'h00);
    #0 check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mode_bits;
    wr(3'd0, 8'hFF);
    rd_check("R2 mode all ones", 3'd0, 8'h42);
    wr(3'd0, 8'hBD);
    rd_check("R2 reserved only", 3'd0, 8'h00);
  endtask

  task automatic t_split;
    wr(3'd1, 8'h01);
    pulses(0, 3);
    pulses(1, 2);
    rd_check("R3 lo enabled", 3'd3, 8'd3);
    rd_check("R3 hi disabled", 3'd4, 8'd0);
    wr(3'd1, 8'h02);
    pulses(0, 2);
    pulses(1, 2);
    rd_check("R3 lo disabled", 3'd3, 8'd3);
    rd_check("R3 hi enabled", 3'd4, 8'd2);
    @(negedge clk); pin_ch1 = 1'b1;
    repeat (20) @(negedge clk); pin_ch1 = 1'b0;
    repeat (4) @(negedge clk);
    rd_check("R10 held level once", 3'd4, 8'd3);
  endtask

  task automatic t_wrap8;
    wr(3'd1, 8'h03);
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hFF);
    pulses(0, 3);
    rd_check("R4 lo wraps", 3'd3, 8'h01);
    rd_check("R4 hi untouched", 3'd4, 8'hFF);
    pulses(1, 1);
    rd_check("R4 hi wraps", 3'd4, 8'h00);
    rd_check("R4 no flag", 3'd2, 8'h00);
  endtask

  task automatic t_cascade;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h40);
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'h12);
    pulses(0, 3);
    rd_check("R5 low byte", 3'd3, 8'h01);
    rd_check("R5 carry into high", 3'd4, 8'h13);
    pulses(1, 2);
    rd_check("R5 ch1 ignored lo", 3'd3, 8'h01);
    rd_check("R5 ch1 ignored hi", 3'd4, 8'h13);
  endtask

  task automatic t_overflow;
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'hFF);
    pulses(0, 1);
    rd_check("R6 lo zero", 3'd3, 8'h00);
    rd_check("R6 hi zero", 3'd4, 8'h00);
    rd_check("R6 flag set", 3'd2, 8'h01);
    #0 check("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h42);
    #1 check("R8 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd2, 8'h00);
    rd_check("R7 write 0 keeps", 3'd2, 8'h01);
    wr(3'd2, 8'h01);
    rd_check("R7 write 1 clears", 3'd2, 8'h00);
    #0 check("R8 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_wins;
    wr(3'd0, 8'h40);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'hFF);
    edge_with_write(3'd2, 8'h01);
    rd_check("R7 set beats clear", 3'd2, 8'h01);
    wr(3'd2, 8'h01);
  endtask

  task automatic t_load_priority;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h10);
    edge_with_write(3'd3, 8'h55);
    rd_check("R9 load beats inc", 3'd3, 8'h55);
    pulses(0, 1);
    rd_check("R9 counts after load", 3'd3, 8'h56);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_bits();
    t_split();
    t_wrap8();
    t_cascade();
    t_overflow();
    t_set_wins();
    t_load_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule